// File: doc/BRIEF.md
# Linked-list context save engine

This block moves a processor's register context between the register file and 64-byte frames in memory. A frame holds sixteen 32-bit words. Frames are chained in memory as two lists. A free pointer names the first unused frame, and the first word of each free frame names the next one. A link pointer names the most recently saved frame. A save takes a frame off the free list and pushes it onto the saved chain. A restore pops the newest saved frame, loads it back into the registers and returns the frame to the free list.

The pipeline starts an operation with a one-cycle request that carries a 2-bit kind. The engine reads operands through a combinational register-file read port. It writes restored values through a register-file write port and a separate status-word write strobe. It reaches memory through a single word port with a valid/ready handshake. When the operation is finished it raises a one-cycle done. If a save finds no free frame, it raises a one-cycle fault and touches nothing. Both pointers are kept inside the engine, start from parameter values at reset, and are visible as outputs.

Top module: `ctx_spill_engine`

## Requirements
- R1: A pointer is turned into a frame address by placing pointer bits 19:16 at address bits 31:28 and pointer bits 15:0 at address bits 21:6. Address bits 27:22 are zero, bits 5:2 hold the word number, and bits 1:0 are zero.
- R2: A save (kind 0 or 1) starts with a read of word 0 of the frame that the free pointer names. The value returned becomes the next free pointer. All writes to the frame come after this read.
- R3: An upper save (kind 0) writes words 0 to 15 with: the link pointer, the status input, A10, A11, D8, D9, D10, D11, A12, A13, A14, A15, D12, D13, D14, D15. Register index 0 to 15 selects D0 to D15, and index 16 to 31 selects A0 to A15.
- R4: A lower save (kind 1) writes words 0 to 15 with: the link pointer, A11, A2, A3, D0, D1, D2, D3, A4, A5, A6, A7, D4, D5, D6, D7.
- R5: A restore (kind 2 or 3, both handled the same way) reads words 0 to 15 of the frame that the link pointer names. Word 1 goes to the status write and words 2 to 15 go to the same registers R3 assigns them. These register and status writes happen only after the sixteenth read and before a final write of the free pointer into word 0. No other register changes.
- R6: After a restore, free pointer bits 19:0 hold the old link pointer's bits 19:0, and free pointer bits 31:20 are unchanged. The link pointer becomes word 0 as it was read.
- R7: After a save, the link pointer is built as follows: bits 31:24 take the priority input at completion, bits 23:20 are kept, and bits 19:0 take the old free pointer's bits 19:0. The free pointer becomes the value read in R2.
- R8: A save requested while free pointer bits 19:0 are zero raises fault for exactly one cycle. It makes no memory access, gives no done, and leaves both pointers unchanged.
- R9: Memory accesses go one at a time in ascending word order. Each access holds its address and direction until ready is seen. Exactly one done pulse follows the last access. Busy is high from acceptance until done, and the pointers change only as done rises.
- R10: A request that arrives while busy is ignored. It causes no extra access and no second operation.
- R11: After reset, busy, done and fault are low and the pointers hold their parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_kind_i | input | 2 | 0 upper save, 1 lower save, 2/3 restore |
| cur_prio_i | input | PRIO_W | Current priority for the link pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle empty free list pulse |
| free_ptr_o | output | 32 | Free-list pointer |
| link_ptr_o | output | 32 | Saved-context link pointer |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| stat_i | input | 32 | Current status word |
| stat_we_o | output | 1 | Status word write enable |
| stat_wdata_o | output | 32 | Restored status word |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts / completes access |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |

## Verification
The bench sets the reset free pointer to a three-frame free list that begins in segment 3, and sets the reset link pointer to a nonzero value with nonzero bits 23:20. With these values the list runs dry after three saves, so the fault path can be reached. Freed frames come back to the head of the list and are used again, and the address formation is exercised with segment and offset both nonzero. The priority width stays at its default of 8.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 16;
  localparam int SLOT_W      = $clog2(FRAME_WORDS);
  localparam int SEG_W       = 4;
  localparam int OFF_W       = 16;
  localparam int BYTE_SH     = 2;
  localparam int REG_IDX_W   = 5;

  typedef enum logic [1:0] {
    K_SAVE_UP  = 2'd0,
    K_SAVE_LO  = 2'd1,
    K_REST     = 2'd2,
    K_REST_EXC = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GRAB,
    S_SPILL,
    S_FILL,
    S_COMMIT,
    S_RELEASE
  } eng_state_e;
endpackage

// File: rtl/ctx_frame_addr.sv
`timescale 1ns/1ps
module ctx_frame_addr
  import ctx_pkg::*;
(
  input  logic [SEG_W+OFF_W-1:0] ptr_i,
  input  logic [SLOT_W-1:0]      slot_i,
  output logic [WORD_W-1:0]      addr_o
);
  localparam int GAP_W = WORD_W - SEG_W - OFF_W - SLOT_W - BYTE_SH;

  // segment to the top nibble, offset scaled to 64-byte frames
  assign addr_o = {ptr_i[SEG_W+OFF_W-1:OFF_W], {GAP_W{1'b0}},
                   ptr_i[OFF_W-1:0], slot_i, {BYTE_SH{1'b0}}};
endmodule

// File: rtl/ctx_slot_map.sv
`timescale 1ns/1ps
module ctx_slot_map
  import ctx_pkg::*;
(
  input  logic                 upper_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic [REG_IDX_W-1:0] idx_o
);
  localparam logic [REG_IDX_W-1:0] IDX_A11 = REG_IDX_W'(27);

  logic [1:0]           grp;
  logic [1:0]           lane;
  logic [REG_IDX_W-1:0] base;

  always_comb begin
    grp  = slot_i[SLOT_W-1:SLOT_W-2];
    lane = slot_i[1:0];
    unique case (grp)
      2'd0:    base = upper_i ? REG_IDX_W'(24) : REG_IDX_W'(16);
      2'd1:    base = upper_i ? REG_IDX_W'(8)  : REG_IDX_W'(0);
      2'd2:    base = upper_i ? REG_IDX_W'(28) : REG_IDX_W'(20);
      default: base = upper_i ? REG_IDX_W'(12) : REG_IDX_W'(4);
    endcase
    idx_o = base + {{(REG_IDX_W-2){1'b0}}, lane};
    if (!upper_i && slot_i == SLOT_W'(1)) idx_o = IDX_A11;
  end
endmodule

// File: rtl/ctx_frame_buf.sv
`timescale 1ns/1ps
module ctx_frame_buf
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wsel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0] rsel_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] head_o
);
  logic [WORD_W-1:0] words [FRAME_WORDS];

  for (genvar i = 0; i < FRAME_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we_i && wsel_i == SLOT_W'(i)) q <= wdata_i;
    end
    assign words[i] = q;
  end

  assign rdata_o = words[rsel_i];
  assign head_o  = words[0];
endmodule

// File: rtl/ctx_spill_engine.sv
`timescale 1ns/1ps
module ctx_spill_engine
  import ctx_pkg::*;
#(
  parameter logic [31:0] FREE_INIT = 32'h0000_0000,
  parameter logic [31:0] LINK_INIT = 32'h0000_0000,
  parameter int          PRIO_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_kind_i,
  input  logic [PRIO_W-1:0]    cur_prio_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [WORD_W-1:0]    free_ptr_o,
  output logic [WORD_W-1:0]    link_ptr_o,
  output logic [REG_IDX_W-1:0] rf_raddr_o,
  input  logic [WORD_W-1:0]    rf_rdata_i,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [WORD_W-1:0]    rf_wdata_o,
  input  logic [WORD_W-1:0]    stat_i,
  output logic                 stat_we_o,
  output logic [WORD_W-1:0]    stat_wdata_o,
  output logic                 mem_valid_o,
  output logic                 mem_we_o,
  output logic [WORD_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  input  logic                 mem_ready_i,
  input  logic [WORD_W-1:0]    mem_rdata_i
);
  localparam int LOW_W    = SEG_W + OFF_W;
  localparam int PRIO_LSB = WORD_W - PRIO_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_WORDS - 1);
  localparam logic [SLOT_W-1:0] STAT_SLOT = SLOT_W'(1);

  eng_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              upper_q, upper_d;
  logic [WORD_W-1:0] nxt_q, nxt_d;
  logic [WORD_W-1:0] free_q, free_d;
  logic [WORD_W-1:0] link_q, link_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;

  logic                 use_free;
  logic [LOW_W-1:0]     frame_ptr;
  logic [REG_IDX_W-1:0] map_idx;
  logic                 buf_we;
  logic [WORD_W-1:0]    buf_rd;
  logic [WORD_W-1:0]    buf_head;
  logic                 acc;

  assign frame_ptr = use_free ? free_q[LOW_W-1:0] : link_q[LOW_W-1:0];
  assign acc       = mem_valid_o && mem_ready_i;

  ctx_frame_addr u_addr (
    .ptr_i  (frame_ptr),
    .slot_i (slot_q),
    .addr_o (mem_addr_o)
  );

  ctx_slot_map u_map (
    .upper_i (upper_q),
    .slot_i  (slot_q),
    .idx_o   (map_idx)
  );

  ctx_frame_buf u_buf (
    .clk     (clk),
    .we_i    (buf_we),
    .wsel_i  (slot_q),
    .wdata_i (mem_rdata_i),
    .rsel_i  (slot_q),
    .rdata_o (buf_rd),
    .head_o  (buf_head)
  );

  // next-state and datapath control
  always_comb begin
    state_d     = state_q;
    slot_d      = slot_q;
    upper_d     = upper_q;
    nxt_d       = nxt_q;
    free_d      = free_q;
    link_d      = link_q;
    done_d      = 1'b0;
    fault_d     = 1'b0;
    use_free    = 1'b0;
    buf_we      = 1'b0;
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    rf_we_o     = 1'b0;
    stat_we_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          slot_d = '0;
          if (!req_kind_i[1]) begin
            if (free_q[LOW_W-1:0] == '0) begin
              fault_d = 1'b1;
            end else begin
              state_d = S_GRAB;
              upper_d = (req_kind_i == K_SAVE_UP);
            end
          end else begin
            state_d = S_FILL;
            upper_d = 1'b1;
          end
        end
      end
      S_GRAB: begin
        use_free    = 1'b1;
        mem_valid_o = 1'b1;
        if (acc) begin
          nxt_d   = mem_rdata_i;
          state_d = S_SPILL;
        end
      end
      S_SPILL: begin
        use_free    = 1'b1;
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        if (slot_q == '0)
          mem_wdata_o = link_q;
        else if (upper_q && slot_q == STAT_SLOT)
          mem_wdata_o = stat_i;
        else
          mem_wdata_o = rf_rdata_i;
        if (acc) begin
          if (slot_q == LAST_SLOT) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
            link_d  = {cur_prio_i, link_q[PRIO_LSB-1:LOW_W], free_q[LOW_W-1:0]};
            free_d  = nxt_q;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      S_FILL: begin
        mem_valid_o = 1'b1;
        if (acc) begin
          buf_we = 1'b1;
          if (slot_q == LAST_SLOT) begin
            state_d = S_COMMIT;
            slot_d  = STAT_SLOT;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      S_COMMIT: begin
        if (slot_q == STAT_SLOT) stat_we_o = 1'b1;
        else                     rf_we_o   = 1'b1;
        if (slot_q == LAST_SLOT) begin
          state_d = S_RELEASE;
          slot_d  = '0;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      S_RELEASE: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = free_q;
        if (acc) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          free_d  = {free_q[WORD_W-1:LOW_W], link_q[LOW_W-1:0]};
          link_d  = buf_head;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
      upper_q <= 1'b0;
      nxt_q   <= '0;
      free_q  <= FREE_INIT;
      link_q  <= LINK_INIT;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      upper_q <= upper_d;
      nxt_q   <= nxt_d;
      free_q  <= free_d;
      link_q  <= link_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign free_ptr_o   = free_q;
  assign link_ptr_o   = link_q;
  assign rf_raddr_o   = map_idx;
  assign rf_waddr_o   = map_idx;
  assign rf_wdata_o   = buf_rd;
  assign stat_wdata_o = buf_rd;
endmodule

// File: rtl/ctx_spill_chk.sv
`timescale 1ns/1ps
module ctx_spill_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic        mem_valid_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ready_i,
  input logic        rf_we_o,
  input logic        stat_we_o,
  input logic [31:0] free_ptr_o,
  input logic [31:0] link_ptr_o
);
  // R9: a waiting access keeps address and direction
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9: accesses only inside an operation
  a_r9_access_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> busy_o);

  // R9: done is a single pulse that ends the operation
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !fault_o);

  // R8: fault makes no access and starts nothing
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !busy_o && !mem_valid_o);

  // R5: register commits never overlap a memory access
  a_r5_commit_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || stat_we_o) |-> busy_o && !mem_valid_o);

  // R9: pointers change only with done
  a_r9_ptr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(free_ptr_o) && $stable(link_ptr_o));
endmodule

bind ctx_spill_engine ctx_spill_chk u_chk (.*);

// File: tb/tb_ctx_spill_engine.sv
`timescale 1ns/1ps
module tb_ctx_spill_engine;
  localparam logic [31:0] FREE0 = 32'h5A03_0005;
  localparam logic [31:0] LINK0 = 32'h11A0_0777;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  prio;
  logic        busy_o, done_o, fault_o;
  logic [31:0] free_ptr_o, link_ptr_o;
  logic [4:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata, rf_wdata_o;
  logic        rf_we_o;
  logic [31:0] stat;
  logic        stat_we_o;
  logic [31:0] stat_wdata_o;
  logic        mem_valid_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ready;
  logic [31:0] mem_rdata;

  always #4 clk = ~clk;

  ctx_spill_engine #(.FREE_INIT(FREE0), .LINK_INIT(LINK0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .cur_prio_i(prio), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .free_ptr_o(free_ptr_o), .link_ptr_o(link_ptr_o),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .stat_i(stat), .stat_we_o(stat_we_o), .stat_wdata_o(stat_wdata_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rf [32];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall_en = 1'b0;

  logic        lg_we   [64];
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  int          lg_cyc  [64];
  int lg_n = 0;
  int n_done = 0;
  int n_fault = 0;
  int first_rfw = -1;
  int last_rfw = -1;

  logic [31:0] m_free, m_link;
  int m_depth = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // R1: frame address from a pointer
  function automatic logic [31:0] faddr(input logic [31:0] p);
    logic [31:0] a;
    a = 32'h0;
    a[31:28] = p[19:16];
    a[21:6]  = p[15:0];
    return a;
  endfunction

  // R3: register index per word in an upper frame
  function automatic int umap(input int k);
    if (k == 2) return 26;
    if (k == 3) return 27;
    if (k < 8)  return 8 + (k - 4);
    if (k < 12) return 28 + (k - 8);
    return 12 + (k - 12);
  endfunction

  // R4: register index per word in a lower frame
  function automatic int lmap(input int k);
    if (k == 1) return 27;
    if (k == 2) return 18;
    if (k == 3) return 19;
    if (k < 8)  return k - 4;
    if (k < 12) return 20 + (k - 8);
    return 4 + (k - 12);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // stimulus side of memory and register file, away from the active edge
  always @(negedge clk) begin
    mem_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    mem_rdata = mrd(mem_addr_o);
    rf_rdata  = rf[rf_raddr_o];
  end

  // monitor, memory writes, register writes, watchdog
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_valid_o && mem_ready) begin
        if (lg_n < 64) begin
          lg_we[lg_n]   = mem_we_o;
          lg_addr[lg_n] = mem_addr_o;
          lg_data[lg_n] = mem_we_o ? mem_wdata_o : mem_rdata;
          lg_cyc[lg_n]  = cyc;
        end
        lg_n++;
        if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
      end
      if (rf_we_o) rf[rf_waddr_o] = rf_wdata_o;
      if (stat_we_o) stat = stat_wdata_o;
      if (rf_we_o || stat_we_o) begin
        if (first_rfw < 0) first_rfw = cyc;
        last_rfw = cyc;
      end
      if (done_o) n_done++;
      if (fault_o) n_fault++;
    end
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] kind, input bit poke, input bit stall);
    logic [31:0] fa, of, ol, st_s, ew, e_free, e_link;
    logic [31:0] pre [16];
    logic [31:0] rfs [32];
    logic [7:0]  pr;
    bit exp_fault, a_ok, d_ok, r_ok;
    int d0, f0, wn, ix;
    stall_en = stall;
    of = m_free;
    ol = m_link;
    exp_fault = !kind[1] && (m_free[19:0] == 20'h0);
    fa = kind[1] ? faddr(m_link) : faddr(m_free);
    for (int k = 0; k < 16; k++) pre[k] = mrd(fa + 32'(4 * k));
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    stat = $urandom;
    for (int i = 0; i < 32; i++) rfs[i] = rf[i];
    st_s = stat;
    pr = 8'($urandom);
    prio = pr;
    lg_n = 0;
    first_rfw = -1;
    last_rfw = -1;
    d0 = n_done;
    f0 = n_fault;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke && !exp_fault) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_kind = ~kind;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    wn = 0;
    while (n_done == d0 && n_fault == f0 && wn < 3000) begin
      @(negedge clk);
      wn++;
    end
    repeat (4) @(negedge clk);
    chk(wn < 3000, "R9 completion", 32'(wn), 32'd3000);

    if (exp_fault) begin
      chk(n_fault - f0 == 1, "R8 one-cycle fault", 32'(n_fault - f0), 32'd1);
      chk(lg_n == 0, "R8 no access", 32'(lg_n), 32'd0);
      chk(n_done == d0, "R8 no done", 32'(n_done - d0), 32'd0);
      chk(free_ptr_o == of && link_ptr_o == ol, "R8 pointers kept", free_ptr_o, of);
      return;
    end

    chk(n_done - d0 == 1, "R9 single done", 32'(n_done - d0), 32'd1);
    chk(lg_n == 17, "R9 access count", 32'(lg_n), 32'd17);
    chk(busy_o == 1'b0, "R10 idle after op", 32'(busy_o), 32'd0);
    if (lg_n != 17) return;

    if (!kind[1]) begin
      chk(!lg_we[0] && lg_addr[0] == fa, "R2 first read word0", lg_addr[0], fa);
      a_ok = 1'b1;
      d_ok = 1'b1;
      for (int k = 0; k < 16; k++) begin
        if (k == 0) ew = ol;
        else if (kind == 2'd0 && k == 1) ew = st_s;
        else if (kind == 2'd0) ew = rfs[umap(k)];
        else ew = rfs[lmap(k)];
        if (!lg_we[k+1] || lg_addr[k+1] != fa + 32'(4 * k)) begin
          if (a_ok) chk(1'b0, "R1 write address", lg_addr[k+1], fa + 32'(4 * k));
          a_ok = 1'b0;
        end
        if (lg_data[k+1] != ew) begin
          if (d_ok) chk(1'b0, kind == 2'd0 ? "R3 upper word" : "R4 lower word", lg_data[k+1], ew);
          d_ok = 1'b0;
        end
      end
      if (a_ok) chk(1'b1, "R1 write address", 0, 0);
      if (d_ok) chk(1'b1, kind == 2'd0 ? "R3 upper word" : "R4 lower word", 0, 0);
      e_link = {pr, ol[23:20], of[19:0]};
      e_free = pre[0];
      chk(link_ptr_o == e_link, "R7 link after save", link_ptr_o, e_link);
      chk(free_ptr_o == e_free, "R7 free after save", free_ptr_o, e_free);
      m_depth++;
    end else begin
      a_ok = 1'b1;
      for (int k = 0; k < 16; k++)
        if (lg_we[k] || lg_addr[k] != fa + 32'(4 * k)) a_ok = 1'b0;
      chk(a_ok, "R1 restore read addresses", lg_addr[0], fa);
      chk(lg_we[16] && lg_addr[16] == fa && lg_data[16] == of, "R5 free pushed to word0", lg_data[16], of);
      chk(first_rfw > lg_cyc[15] && last_rfw < lg_cyc[16], "R5 commit after reads", 32'(first_rfw), 32'(lg_cyc[15]));
      chk(stat == pre[1], "R5 status restored", stat, pre[1]);
      r_ok = 1'b1;
      for (int k = 2; k < 16; k++)
        if (rf[umap(k)] != pre[k]) begin
          if (r_ok) chk(1'b0, "R5 upper register", rf[umap(k)], pre[k]);
          r_ok = 1'b0;
        end
      if (r_ok) chk(1'b1, "R5 upper register", 0, 0);
      r_ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
        ix = i;
        if (!(ix == 26 || ix == 27 || (ix >= 8 && ix <= 15) || ix >= 28))
          if (rf[i] != rfs[i]) begin
            if (r_ok) chk(1'b0, "R5 other register untouched", rf[i], rfs[i]);
            r_ok = 1'b0;
          end
      end
      if (r_ok) chk(1'b1, "R5 other register untouched", 0, 0);
      e_free = {of[31:20], ol[19:0]};
      e_link = pre[0];
      chk(free_ptr_o == e_free, "R6 free after restore", free_ptr_o, e_free);
      chk(link_ptr_o == e_link, "R6 link after restore", link_ptr_o, e_link);
      m_depth--;
    end
    m_free = free_ptr_o;
    m_link = link_ptr_o;
    if (free_ptr_o != e_free || link_ptr_o != e_link) begin
      m_free = e_free;
      m_link = e_link;
    end
  endtask

  initial begin
    int r;
    logic [1:0] k;
    void'($urandom(32'd1357));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'd0;
    prio = 8'h0;
    stat = 32'h0;
    mem_ready = 1'b0;
    mem_rdata = 32'h0;
    rf_rdata = 32'h0;
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    // three-frame free list ending in an empty pointer
    mem[faddr(32'h0003_0005)] = 32'h7E01_0040;
    mem[faddr(32'h0001_0040)] = 32'h0C00_0002;
    mem[faddr(32'h0000_0002)] = 32'hFFF0_0000;
    m_free = FREE0;
    m_link = LINK0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(!busy_o && !done_o && !fault_o, "R11 flags low", {29'h0, busy_o, done_o, fault_o}, 32'h0);
    chk(free_ptr_o == FREE0, "R11 free reset value", free_ptr_o, FREE0);
    chk(link_ptr_o == LINK0, "R11 link reset value", link_ptr_o, LINK0);

    // directed: R10 poke during an upper save, then lower save with stalls
    run_op(2'd0, 1'b1, 1'b0);
    run_op(2'd1, 1'b0, 1'b1);
    run_op(2'd0, 1'b1, 1'b1);
    // list now empty: R8
    run_op(2'd1, 1'b0, 1'b0);
    run_op(2'd0, 1'b0, 1'b1);
    // both restore kinds, with a poke during one
    run_op(2'd2, 1'b1, 1'b0);
    run_op(2'd3, 1'b0, 1'b1);
    run_op(2'd0, 1'b0, 1'b1);
    run_op(2'd3, 1'b0, 1'b0);
    run_op(2'd2, 1'b0, 1'b1);

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      r = int'($urandom % 4);
      if (m_depth == 0 || r < 2) k = {1'b0, r[0]};
      else k = {1'b1, r[0]};
      run_op(k, r == 1, ($urandom % 2) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule